// File: doc/BRIEF.md
# Dual-Domain Password Access Guard

This block sits in front of a small word-addressed register store and decides which accesses may reach it. Two independent 32-bit secrets are kept, one for a host domain and one for a module domain. A software agent unlocks a domain by writing a candidate value into a four-byte entry word. The candidate can arrive as one full-word write or as separate single-byte writes. While the candidate equals a domain's stored secret, that domain's unlock flag is high. A per-word attribute table, set through parameters, names each storage word's owning domain and says whether reads, writes or both are refused while that owner is locked.

A secret is replaced by writing its setting word with all four byte enables set, and only while its own domain is unlocked. The entry word keeps the old value, so the domain locks on the next cycle and stays locked until the new value is entered. The entry word and both setting words never show their contents. A read of any of them returns zero. A refused read returns all ones, and a refused write is dropped with no indication. The register port is a plain control port with no valid/ready handshake and no back-pressure: each write takes effect at the clock edge where it is presented, and read data appears on the cycle after the read strobe.

Word map: word 0 is the entry word, word 1 sets the host secret, word 2 sets the module secret, and words 3 and up are storage. Byte lane k of `reg_wdata` is bits 8k+7..8k and is enabled by `reg_be[k]`. By default, word 3 has no owner. Words 4 and 5 belong to the host: word 4 refuses writes and word 5 refuses reads and writes. Words 6 and 7 belong to the module: word 6 refuses writes and word 7 refuses reads.

Top module: `pw_guard`

## Requirements
- R1: After reset both unlock flags are 0, the read data is 0, the entry word holds 0, both secrets hold 32'hFFFF_FFFF, and all storage words hold 0.
- R2: A full-word write of a value equal to a domain's secret into word 0 raises that domain's unlock flag on the cycle after the write. A domain whose secret differs stays locked.
- R3: Single-byte writes to word 0 update only the enabled lane. The flag rises only after the last mismatching byte has been written.
- R4: A read of word 0, 1 or 2 returns 32'h0000_0000 whatever they hold.
- R5: A write to a write-refusing word whose owner is locked leaves the word unchanged. The same write is stored once the owner is unlocked.
- R6: A read of a read-refusing word whose owner is locked returns 32'hFFFF_FFFF. Once the owner is unlocked it returns the stored value.
- R7: A write to a setting word while its domain is locked leaves that secret unchanged.
- R8: A write to a setting word with any byte enable clear leaves that secret unchanged, even while its domain is unlocked.
- R9: A full-word setting write while the domain is unlocked stores the new secret, and the domain locks on the next cycle. Entering the new value unlocks it again. The old value no longer unlocks it.
- R10: Each flag depends only on its own secret. Unlocking one domain grants no access to words owned by the other.
- R11: A word with no owner is always readable and writable.
- R12: Writing an entry value that no longer matches drops a previously high flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address (ADDR_W = log2 NUM_WORDS) |
| reg_wdata | input | 32 | Write data, four byte lanes |
| reg_be | input | 4 | Byte enables for a write |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe; data valid on the next cycle |
| reg_rdata | output | 32 | Registered read data |
| host_unlocked | output | 1 | Host domain currently unlocked |
| module_unlocked | output | 1 | Module domain currently unlocked |

## Verification
The entry word is tried with three input patterns. Full-word writes of the matching value and of a non-matching value separate an equality compare from a partial one. A byte-by-byte sequence, checked after each byte, shows that only the enabled lane is merged and that the flag waits for all four. Setting writes are tried locked, with a partial enable mask, and complete, and then the old and new values are re-entered. This shows that the setting gate checks both the enables and the domain. Storage accesses are repeated with each domain open in turn, which tells the host and module owner masks apart and separates read refusal from write refusal.

// File: rtl/pw_guard_pkg.sv
`timescale 1ns/1ps
package pw_guard_pkg;
  localparam int PW_W       = 32;
  localparam int LANES      = PW_W / 8;
  localparam int ENTRY_WORD = 0;
  localparam int SET_BASE   = 1;   // host setting word, module is SET_BASE+1
  localparam int FIRST_DATA = 3;
  localparam int NUM_DOM    = 2;
  localparam logic [PW_W-1:0] BLANK_VAL   = '0;
  localparam logic [PW_W-1:0] REFUSED_VAL = '1;
  localparam logic [PW_W-1:0] SECRET_INIT = '1;

  typedef enum logic [0:0] {DOM_HOST = 1'b0, DOM_MODULE = 1'b1} dom_e;
endpackage

// File: rtl/pw_entry_reg.sv
`timescale 1ns/1ps
module pw_entry_reg
  import pw_guard_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PW_W-1:0]   wdata,
  input  logic [LANES-1:0]  be,
  output logic [PW_W-1:0]   entry
);
  logic [PW_W-1:0] entry_q;
  logic            hit;

  assign hit   = wr && (addr == ADDR_W'(ENTRY_WORD));
  assign entry = entry_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[8*l +: 8] <= '0;
      else if (hit && be[l])
        entry_q[8*l +: 8] <= wdata[8*l +: 8];
    end

    // R3
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !be[l]) |=> $stable(entry_q[8*l +: 8]));
  end
endmodule

// File: rtl/pw_domain.sv
`timescale 1ns/1ps
module pw_domain
  import pw_guard_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int SET_WORD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PW_W-1:0]   wdata,
  input  logic [LANES-1:0]  be,
  input  logic [PW_W-1:0]   entry,
  output logic              unlocked
);
  logic [PW_W-1:0] secret_q;
  logic            set_hit;
  logic            set_take;

  assign unlocked = (entry == secret_q);
  assign set_hit  = wr && (addr == ADDR_W'(SET_WORD));
  assign set_take = set_hit && (&be) && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      secret_q <= SECRET_INIT;
    else if (set_take)
      secret_q <= wdata;
  end

  // R7
  locked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !unlocked) |=> $stable(secret_q));

  // R8
  partial_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !(&be)) |=> $stable(secret_q));

  // R9
  new_secret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && (&be) && unlocked) |=> (secret_q == $past(wdata)));
endmodule

// File: rtl/pw_store.sv
`timescale 1ns/1ps
module pw_store
  import pw_guard_pkg::*;
#(
  parameter int               NUM_WORDS = 8,
  parameter int               ADDR_W    = 3,
  parameter logic [NUM_WORDS-1:0] HOST_OWN = 8'b0011_0000,
  parameter logic [NUM_WORDS-1:0] MOD_OWN  = 8'b1100_0000,
  parameter logic [NUM_WORDS-1:0] WR_LOCK  = 8'b0111_0000,
  parameter logic [NUM_WORDS-1:0] RD_LOCK  = 8'b1010_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PW_W-1:0]    wdata,
  input  logic [LANES-1:0]   be,
  input  logic [NUM_DOM-1:0] dom_open,
  output logic [PW_W-1:0]    rd_word,
  output logic               rd_refused
);
  logic [NUM_WORDS-1:0][PW_W-1:0] word_q;
  logic [NUM_WORDS-1:0]           owner_shut;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign owner_shut[w] = (HOST_OWN[w] && !dom_open[DOM_HOST]) ||
                           (MOD_OWN[w]  && !dom_open[DOM_MODULE]);
    if (w < FIRST_DATA) begin : g_none
      assign word_q[w] = '0;
    end else begin : g_data
      logic wr_hit;
      logic wr_ok;
      assign wr_hit = wr && (addr == ADDR_W'(w));
      assign wr_ok  = wr_hit && !(WR_LOCK[w] && owner_shut[w]);

      for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            word_q[w][8*l +: 8] <= '0;
          else if (wr_ok && be[l])
            word_q[w][8*l +: 8] <= wdata[8*l +: 8];
        end
      end

      // R5
      if (WR_LOCK[w]) begin : g_wchk
        wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_hit && owner_shut[w]) |=> $stable(word_q[w]));
      end
      // R11
      if (!HOST_OWN[w] && !MOD_OWN[w]) begin : g_ochk
        open_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_hit && (&be)) |=> (word_q[w] == $past(wdata)));
      end
    end
  end

  assign rd_word    = word_q[addr];
  assign rd_refused = RD_LOCK[addr] && owner_shut[addr];
endmodule

// File: rtl/pw_guard.sv
`timescale 1ns/1ps
module pw_guard
  import pw_guard_pkg::*;
#(
  parameter int                   NUM_WORDS = 8,
  parameter logic [NUM_WORDS-1:0] HOST_OWN  = 8'b0011_0000,
  parameter logic [NUM_WORDS-1:0] MOD_OWN   = 8'b1100_0000,
  parameter logic [NUM_WORDS-1:0] WR_LOCK   = 8'b0111_0000,
  parameter logic [NUM_WORDS-1:0] RD_LOCK   = 8'b1010_0000,
  localparam int                  ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              host_unlocked,
  output logic              module_unlocked
);
  logic [PW_W-1:0]    entry;
  logic [NUM_DOM-1:0] dom_open;
  logic [PW_W-1:0]    rd_word;
  logic               rd_refused;
  logic               hidden_hit;
  logic [PW_W-1:0]    rdata_q;

  pw_entry_reg #(.ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .entry(entry)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pw_domain #(.ADDR_W(ADDR_W), .SET_WORD(SET_BASE + d)) u_dom (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .be(reg_be), .entry(entry),
      .unlocked(dom_open[d])
    );
  end

  pw_store #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
    .HOST_OWN(HOST_OWN), .MOD_OWN(MOD_OWN),
    .WR_LOCK(WR_LOCK), .RD_LOCK(RD_LOCK)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .dom_open(dom_open),
    .rd_word(rd_word), .rd_refused(rd_refused)
  );

  assign hidden_hit = (reg_addr < ADDR_W'(FIRST_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (reg_rd) begin
      if (hidden_hit)      rdata_q <= BLANK_VAL;
      else if (rd_refused) rdata_q <= REFUSED_VAL;
      else                 rdata_q <= rd_word;
    end
  end

  assign reg_rdata       = rdata_q;
  assign host_unlocked   = dom_open[DOM_HOST];
  assign module_unlocked = dom_open[DOM_MODULE];

  // R4
  blank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hidden_hit) |=> (reg_rdata == '0));

  // R6
  refused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hidden_hit && rd_refused) |=> (reg_rdata == '1));

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> ($stable(host_unlocked) && $stable(module_unlocked)));
endmodule

// File: tb/pw_guard_tb.sv
`timescale 1ns/1ps
module pw_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        host_unlocked;
  logic        module_unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pw_guard u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .host_unlocked(host_unlocked), .module_unlocked(module_unlocked)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [2:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd_word(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic flags(string req, logic h, logic m);
    chk({req, " host flag"}, {31'd0, host_unlocked}, {31'd0, h});
    chk({req, " module flag"}, {31'd0, module_unlocked}, {31'd0, m});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    flags("R1", 1'b0, 1'b0);
    chk("R1 rdata", reg_rdata, 32'h0);
    rd_word(3'd3, v); chk("R1 storage", v, 32'h0);
  endtask

  task automatic t_open_word();
    logic [31:0] v;
    wr_word(3'd3, 32'hA5A5_0001, 4'hF);
    rd_word(3'd3, v); chk("R11 open word", v, 32'hA5A5_0001);
  endtask

  task automatic t_locked_host();
    logic [31:0] v;
    wr_word(3'd4, 32'h1111_2222, 4'hF);
    rd_word(3'd4, v); chk("R5 dropped write", v, 32'h0);
    rd_word(3'd5, v); chk("R6 refused read", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_locked_setting();
    wr_word(3'd1, 32'h1234_5678, 4'hF);
    wr_word(3'd0, 32'h1234_5678, 4'hF);
    flags("R7", 1'b0, 1'b0);
  endtask

  task automatic t_default_entry();
    wr_word(3'd0, 32'hFFFF_FFFF, 4'hF);
    flags("R2", 1'b1, 1'b1);
  endtask

  task automatic t_setting_rules();
    wr_word(3'd1, 32'h0000_0000, 4'h3);
    flags("R8", 1'b1, 1'b1);
    wr_word(3'd1, 32'hCAFE_F00D, 4'hF);
    flags("R9 relock", 1'b0, 1'b1);
  endtask

  task automatic t_blank_reads();
    logic [31:0] v;
    rd_word(3'd0, v); chk("R4 entry", v, 32'h0);
    rd_word(3'd1, v); chk("R4 host set", v, 32'h0);
    rd_word(3'd2, v); chk("R4 module set", v, 32'h0);
  endtask

  task automatic t_module_domain();
    logic [31:0] v;
    wr_word(3'd4, 32'h4444_0000, 4'hF);
    rd_word(3'd4, v); chk("R10 host word write", v, 32'h0);
    rd_word(3'd5, v); chk("R10 host word read", v, 32'hFFFF_FFFF);
    wr_word(3'd7, 32'h7777_0007, 4'hF);
    rd_word(3'd7, v); chk("R6 open owner read", v, 32'h7777_0007);
    wr_word(3'd2, 32'h0BAD_BEEF, 4'hF);
    flags("R9 module relock", 1'b0, 1'b0);
    rd_word(3'd7, v); chk("R6 module refused", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_byte_entry();
    wr_word(3'd0, 32'h0000_000D, 4'h1);
    flags("R3 byte0", 1'b0, 1'b0);
    wr_word(3'd0, 32'h0000_F000, 4'h2);
    wr_word(3'd0, 32'h00FE_0000, 4'h4);
    flags("R3 byte2", 1'b0, 1'b0);
    wr_word(3'd0, 32'hCA00_0000, 4'h8);
    flags("R3 byte3 R9 new value", 1'b1, 1'b0);
  endtask

  task automatic t_unlocked_access();
    logic [31:0] v;
    wr_word(3'd4, 32'h1111_2222, 4'hF);
    rd_word(3'd4, v); chk("R5 accepted write", v, 32'h1111_2222);
    wr_word(3'd5, 32'h5555_AAAA, 4'hF);
    rd_word(3'd5, v); chk("R6 unlocked read", v, 32'h5555_AAAA);
  endtask

  task automatic t_relock();
    wr_word(3'd0, 32'h0000_0011, 4'h1);
    flags("R12", 1'b0, 1'b0);
    wr_word(3'd0, 32'hFFFF_FFFF, 4'hF);
    flags("R9 old value", 1'b0, 1'b0);
    wr_word(3'd0, 32'h0BAD_BEEF, 4'hF);
    flags("R10 module only", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_word();
    t_locked_host();
    t_locked_setting();
    t_default_entry();
    t_setting_rules();
    t_blank_reads();
    t_module_domain();
    t_byte_entry();
    t_unlocked_access();
    t_relock();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule